// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives characters over a clocked serial link on which it is the clock master. It divides the system clock by a programmable reload value to form the serial clock. It samples the data line on each falling (trailing) edge of that clock and shifts in characters of 8 or 9 bits, least significant bit first. Each finished character goes to a downstream buffer through a valid/ready stream port.

Two enables start reception. A single-character enable is set by a one-cycle pulse and clears itself when its character completes. A continuous enable is a level, and while it is high characters follow one another with no gap in the clock. The continuous enable wins over the single one. Dropping the continuous enable while a character is partly received (with the single enable clear) stops the clock at once and throws the partial bits away. Dropping the port enable resets the receiver.

Back-pressure works as follows. A completed character is held on `out_data` with `out_valid` high until a cycle in which `out_ready` is high. While a character waits unaccepted, or while the buffer raises `stall` (its overrun signal), the engine freezes its clock. The serial clock holds its level, no edge is produced and no bit is sampled. The engine resumes when both conditions clear.

Top module: `sync_rx_master`

## Requirements
- R1: The serial clock idles low. Each bit is a low half followed by a high half, each lasting `div_reload`+1 system clock cycles, so the time between rising edges is 2*(`div_reload`+1) cycles.
- R2: Data is sampled at each falling serial clock edge, first bit into bit 0. In 8-bit mode (`nine_bit`=0) the character appears on `out_data[7:0]` with `out_data[8]`=0. In 9-bit mode the last bit received appears on `out_data[8]`.
- R3: A `once_set` pulse with the continuous enable low produces exactly 8 (or 9) rising serial clock edges. `once_en` reads 1 until the character completes and reads 0 from the cycle in which its `out_valid` rises.
- R4: While `cont_en` is high and nothing holds the engine, characters are received back to back. The rising-edge period stays 2*(`div_reload`+1) across character boundaries.
- R5: With both enables set, `once_en` clears after the first character and reception continues under `cont_en`.
- R6: Lowering `cont_en` in the middle of a character (with `once_en` at 0) forces the serial clock low on the next cycle. The partial character is never presented, and the next character is assembled from fresh bits only.
- R7: While `stall` is high the serial clock produces no edge and no new character starts. Reception resumes correctly when `stall` falls.
- R8: With `port_en` low, `sck`, `out_valid` and `once_en` are 0 from the next cycle, any partial character is dropped, and `once_set` is ignored.
- R9: `out_valid` stays high with `out_data` unchanged until `out_ready` is high. No serial clock edge is produced while a character waits.
- R10: After reset, `sck`, `out_valid` and `once_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; low resets the receiver |
| cont_en | input | 1 | Continuous receive enable (level) |
| once_set | input | 1 | One-cycle pulse that sets the single-character enable |
| nine_bit | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| div_reload | input | 16 | Half-period reload value of the serial clock divider |
| stall | input | 1 | Downstream overrun; freezes the engine |
| sdata | input | 1 | Serial data line |
| sck | output | 1 | Generated serial clock |
| once_en | output | 1 | Current state of the single-character enable |
| out_valid | output | 1 | Completed character available |
| out_ready | input | 1 | Downstream accepts the character |
| out_data | output | 9 | Received character |

## Verification
A character's `out_valid` rises on the same edge as its last falling serial clock edge, 2*N*(`div_reload`+1) cycles after the start decision for N data bits. `once_en` clears on that same edge. An abort or port disable shows on the outputs one cycle after the input changes. The bench drives inputs and samples outputs on the falling system clock edge. It presents each data bit when it sees the serial clock rise, which is at least one cycle before the sampling edge. It compares characters in a scoreboard only at the handshake, and reads the clock-edge counts and periods only once the relevant character has been accepted.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/sync_rx_divider.sv
module sync_rx_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= reload;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic              sdata,
  input  logic              nine,
  output logic              last,
  output logic [CHAR_W-1:0] word
);
  localparam int CNT_W = $clog2(CHAR_W + 1);
  localparam logic [CNT_W-1:0] IDX_NINE  = CNT_W'(CHAR_W - 1);
  localparam logic [CNT_W-1:0] IDX_EIGHT = CNT_W'(CHAR_W - 2);

  logic [CHAR_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CHAR_W-1:0] nxt;

  assign nxt  = {sdata, sh_q};
  assign last = (cnt_q == (nine ? IDX_NINE : IDX_EIGHT));
  assign word = nine ? nxt : {1'b0, nxt[CHAR_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sample) begin
      sh_q  <= nxt[CHAR_W-1:1];
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: the bit counter never runs past the last bit of a 9-bit character
  p_bitcnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= IDX_NINE);
endmodule

// File: rtl/sync_rx_seq.sv
module sync_rx_seq
  import sync_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic cont_en,
  input  logic once_set,
  input  logic nine_in,
  input  logic hold,
  input  logic tick,
  input  logic last,
  output logic sck,
  output logic load,
  output logic run,
  output logic sample,
  output logic done,
  output logic clr,
  output logic nine_q,
  output logic once_en
);
  rx_phase_e phase_q;
  logic      once_q;
  logic      en_any;
  logic      busy;
  logic      abort;

  assign en_any  = once_q || cont_en;
  assign busy    = (phase_q != PH_IDLE);
  assign abort   = busy && (!port_en || !en_any);
  assign load    = port_en && !busy && en_any && !hold;
  assign run     = busy && !abort && !hold;
  assign sample  = tick && (phase_q == PH_HIGH);
  assign done    = sample && last;
  assign clr     = load || abort || !port_en;
  assign sck     = (phase_q == PH_HIGH);
  assign once_en = once_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      once_q  <= 1'b0;
      nine_q  <= 1'b0;
    end else if (!port_en) begin
      phase_q <= PH_IDLE;
      once_q  <= 1'b0;
    end else begin
      if (abort) begin
        phase_q <= PH_IDLE;
      end else if (load) begin
        phase_q <= PH_LOW;
        nine_q  <= nine_in;
      end else if (tick) begin
        if (phase_q == PH_LOW)  phase_q <= PH_HIGH;
        else if (done)          phase_q <= cont_en ? PH_LOW : PH_IDLE;
        else                    phase_q <= PH_LOW;
      end
      if (once_set)  once_q <= 1'b1;
      else if (done) once_q <= 1'b0;
    end
  end

  // R3: completing a character clears the single enable
  p_once_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && done && !once_set |=> !once_q);

  // R4: continuous mode chains straight into the next low half
  p_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && done && cont_en |=> phase_q == PH_LOW);

  // R6: losing every enable mid-character returns to idle at once
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && busy && !once_q && !cont_en |=> phase_q == PH_IDLE);

  // R7: while held, the clock phase does not move
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && en_any && hold |=> $stable(phase_q));
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              cont_en,
  input  logic              once_set,
  input  logic              nine_bit,
  input  logic [DIV_W-1:0]  div_reload,
  input  logic              stall,
  input  logic              sdata,
  output logic              sck,
  output logic              once_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W:0]   out_data
);
  localparam int CHAR_W = DATA_W + 1;

  logic              hold;
  logic              tick;
  logic              last;
  logic              load;
  logic              run;
  logic              sample;
  logic              done;
  logic              clr;
  logic              nine_q;
  logic [CHAR_W-1:0] word;
  logic              valid_q;
  logic [CHAR_W-1:0] data_q;

  assign hold      = stall || (valid_q && !out_ready);
  assign out_valid = valid_q;
  assign out_data  = data_q;

  sync_rx_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .cont_en  (cont_en),
    .once_set (once_set),
    .nine_in  (nine_bit),
    .hold     (hold),
    .tick     (tick),
    .last     (last),
    .sck      (sck),
    .load     (load),
    .run      (run),
    .sample   (sample),
    .done     (done),
    .clr      (clr),
    .nine_q   (nine_q),
    .once_en  (once_en)
  );

  sync_rx_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .run    (run),
    .reload (div_reload),
    .tick   (tick)
  );

  sync_rx_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .sample (sample),
    .sdata  (sdata),
    .nine   (nine_q),
    .last   (last),
    .word   (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (!port_en) begin
      valid_q <= 1'b0;
    end else if (done) begin
      valid_q <= 1'b1;
      data_q  <= word;
    end else if (valid_q && out_ready) begin
      valid_q <= 1'b0;
    end
  end

  // R8: disabling the port clears clock, output and single enable
  p_port_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sck && !out_valid && !once_en);

  // R9: an unaccepted character stays valid and unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && out_valid && !out_ready |=>
      (!port_en || (out_valid && $stable(out_data))));

  // R9: no serial clock rise while a character waits
  p_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> !$rose(sck));
endmodule

// File: tb/tb_sync_rx_master.sv
module tb_sync_rx_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int PER = 2 * (DIV + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic        cont_en = 1'b0;
  logic        once_set = 1'b0;
  logic        nine_bit = 1'b0;
  logic [15:0] div_reload = 16'(DIV);
  logic        stall = 1'b0;
  logic        sdata = 1'b0;
  logic        sck;
  logic        once_en;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [8:0]  out_data;

  sync_rx_master dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
    .once_set(once_set), .nine_bit(nine_bit), .div_reload(div_reload),
    .stall(stall), .sdata(sdata), .sck(sck), .once_en(once_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int pops = 0;
  int rises = 0;
  int cyc = 0;
  int last_rise = 0;
  bit have_rise = 0;
  int pmin = 0;
  int pmax = 0;
  bit sck_prev = 0;
  bit        bq[$];
  logic [8:0] eq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: serial data driver and scoreboard
  always @(negedge clk) begin
    cyc++;
    if (sck && !sck_prev) begin
      rises++;
      if (have_rise) begin
        if (pmin == 0 || cyc - last_rise < pmin) pmin = cyc - last_rise;
        if (cyc - last_rise > pmax) pmax = cyc - last_rise;
      end
      have_rise = 1;
      last_rise = cyc;
      if (bq.size() > 0) sdata = bq.pop_front();
    end
    sck_prev = sck;
    if (out_valid && out_ready) begin
      if (eq.size() == 0) begin
        check(0, "R6 unexpected character", int'(out_data), 0);
      end else begin
        logic [8:0] e;
        e = eq.pop_front();
        check(out_data == e, "R2 character data", int'(out_data), int'(e));
      end
      pops++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  task automatic send_char(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) bq.push_back(v[i]);
    eq.push_back(n == 9 ? v : {1'b0, v[7:0]});
  endtask

  task automatic pulse_once();
    @(negedge clk) once_set = 1'b1;
    @(negedge clk) once_set = 1'b0;
  endtask

  task automatic wait_pops(input int target);
    while (pops < target) @(negedge clk);
  endtask

  task automatic wait_rises(input int target);
    while (rises < target) @(negedge clk);
  endtask

  task automatic reset_meas();
    have_rise = 0; pmin = 0; pmax = 0; rises = 0;
  endtask

  initial begin
    int r0;
    logic s0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(sck == 0 && out_valid == 0 && once_en == 0, "R10 reset state",
          {sck, out_valid, once_en}, 0);
    rst_n = 1'b1;
    @(negedge clk) port_en = 1'b1;

    // R3 / R1 / R2: single 8-bit character
    reset_meas();
    nine_bit = 1'b0;
    send_char(9'h0A5, 8);
    pulse_once();
    check(once_en == 1, "R3 once_en set", once_en, 1);
    wait_pops(1);
    check(once_en == 0, "R3 once_en cleared", once_en, 0);
    check(rises == 8, "R3 eight clock pulses", rises, 8);
    check(pmin == PER && pmax == PER, "R1 bit period", pmax, PER);
    repeat (20) @(negedge clk);
    check(sck == 0 && rises == 8, "R1 clock idles low", rises, 8);

    // R2 / R3: single 9-bit character
    reset_meas();
    nine_bit = 1'b1;
    send_char(9'h13C, 9);
    pulse_once();
    wait_pops(2);
    check(rises == 9, "R3 nine clock pulses", rises, 9);
    nine_bit = 1'b0;
    repeat (10) @(negedge clk);

    // R4: continuous back-to-back characters
    reset_meas();
    send_char(9'h03C, 8);
    send_char(9'h0C3, 8);
    send_char(9'h001, 8);
    @(negedge clk) cont_en = 1'b1;
    wait_pops(5);
    cont_en = 1'b0;
    check(pmin == PER && pmax == PER, "R4 no gap between characters", pmin, PER);
    repeat (30) @(negedge clk);
    bq.delete();

    // R5: both enables, continuous governs after the first
    send_char(9'h05A, 8);
    send_char(9'h0FF, 8);
    @(negedge clk) begin cont_en = 1'b1; once_set = 1'b1; end
    @(negedge clk) once_set = 1'b0;
    wait_pops(6);
    check(once_en == 0, "R5 once_en cleared after first", once_en, 0);
    wait_pops(7);
    check(pops == 7, "R5 continuous keeps receiving", pops, 7);
    cont_en = 1'b0;
    repeat (30) @(negedge clk);
    bq.delete();

    // R6: abort mid-character
    reset_meas();
    for (int i = 0; i < 8; i++) bq.push_back(1'b1);
    @(negedge clk) cont_en = 1'b1;
    wait_rises(3);
    cont_en = 1'b0;
    @(negedge clk);
    check(sck == 0, "R6 clock stops at once", sck, 0);
    r0 = rises;
    repeat (60) @(negedge clk);
    check(rises == r0 && pops == 7, "R6 partial discarded", pops, 7);
    bq.delete();
    send_char(9'h012, 8);
    pulse_once();
    wait_pops(8);
    check(pops == 8, "R6 fresh character after abort", pops, 8);

    // R7: stall freezes the clock
    reset_meas();
    send_char(9'h0E7, 8);
    pulse_once();
    wait_rises(2);
    stall = 1'b1;
    @(negedge clk);
    r0 = rises; s0 = sck;
    repeat (20) @(negedge clk);
    check(rises == r0 && sck == s0, "R7 no edges while stalled", rises, r0);
    stall = 1'b0;
    wait_pops(9);
    check(rises == 8, "R7 resumes after stall", rises, 8);
    repeat (10) @(negedge clk);

    // R9: back-pressure holds data and clock
    out_ready = 1'b0;
    send_char(9'h081, 8);
    send_char(9'h07E, 8);
    @(negedge clk) cont_en = 1'b1;
    while (!out_valid) @(negedge clk);
    r0 = rises;
    repeat (30) @(negedge clk);
    check(out_valid == 1, "R9 valid held", out_valid, 1);
    check(out_data == 9'h081, "R9 data held", int'(out_data), 9'h081);
    check(rises == r0 && sck == 0, "R9 clock frozen while waiting", rises, r0);
    out_ready = 1'b1;
    wait_pops(11);
    cont_en = 1'b0;
    repeat (30) @(negedge clk);
    bq.delete();

    // R8: port disable mid-character
    for (int i = 0; i < 8; i++) bq.push_back(1'b0);
    reset_meas();
    pulse_once();
    wait_rises(4);
    port_en = 1'b0;
    @(negedge clk);
    check(sck == 0 && out_valid == 0 && once_en == 0, "R8 port off clears",
          {sck, out_valid, once_en}, 0);
    pulse_once();
    @(negedge clk);
    check(once_en == 0, "R8 once_set ignored while off", once_en, 0);
    repeat (40) @(negedge clk);
    check(pops == 11, "R8 partial dropped", pops, 11);
    bq.delete();
    port_en = 1'b1;
    send_char(9'h0C9, 8);
    pulse_once();
    wait_pops(12);
    check(eq.size() == 0, "R8 clean restart", eq.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule